// File: doc/BRIEF.md
# Discrete PI Speed Regulator

This block turns a speed target and a measured speed into an 8-bit PWM duty command using a discrete proportional-integral law. Once per PWM period the surrounding logic raises a single-cycle update strobe. On that strobe the block latches the speed error, which is the target minus the measured value. It then forms a proportional term and an accumulated integral term from two independent gains, adds them, and clamps the sum into the duty range.

Both speeds are signed two's-complement numbers. Each gain is an unsigned fixed-point number with eight fractional bits. A product is scaled back to integer units by an arithmetic right shift, so the result rounds toward minus infinity. The duty output keeps its value between updates. A one-cycle valid pulse marks each new duty value so that the PWM generator can pick it up at its next period boundary. The integrator stops growing while the output sits at a limit and the error would drive it further past that limit, so the loop recovers at once when the error reverses.

Top module: `speed_pi_regulator`

## Requirements
- R1: A synchronous active-high reset clears the integrator and sets `duty` to 0 and `dutyValid` to 0. After reset, an update with zero error and zero gains yields duty 0.
- R2: On a cycle where `updateStrobe` is 1, the error err = refSpeed − actSpeed is captured as a signed value one bit wider than the speed inputs.
- R3: `dutyValid` is 1 exactly two clock edges after each strobed cycle and lasts one cycle. `duty` takes its new value on the same edge.
- R4: The proportional term is p = (gainP × err) >>> 8, an arithmetic shift that floors, for example gain 0x0080 with err 7 gives 3. Gains are unsigned with 8 fractional bits, so 0x0100 means 1.0.
- R5: Each update forms iNew = integ + ((gainI × err) >>> 8), using the same fixed-point format.
- R6: duty = p + iNew, clamped to 0 when the sum is negative and to 255 when it exceeds 255.
- R7: The integrator keeps iNew unless one of two conditions holds: the sum exceeds 255 with err > 0, or the sum is below 0 with err < 0. In either case it keeps its old value.
- R8: Strobes in consecutive cycles each produce their own update, in order. `dutyValid` is then high for consecutive cycles.
- R9: With no strobe, changes on refSpeed, actSpeed or the gains leave `duty` unchanged and `dutyValid` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| updateStrobe | input | 1 | One-cycle request to compute a new duty value |
| refSpeed | input | 16 | Target speed, signed |
| actSpeed | input | 16 | Measured speed, signed |
| gainP | input | 16 | Proportional gain, unsigned, 8 fractional bits |
| gainI | input | 16 | Integral gain, unsigned, 8 fractional bits |
| duty | output | 8 | Clamped duty command |
| dutyValid | output | 1 | One-cycle pulse marking a new duty value |

## Verification
Two things can happen in the same cycle: a new error is captured for one strobe while the previous strobe's duty and integrator are committed. The bench provokes this with strobes on back-to-back cycles that carry different errors. It then checks that each of the two valid cycles carries the value computed from its own error, chained through the integrator. A second overlap, saturation together with the integrator freeze, is driven by errors that overshoot 255. A reversed error must then pull the duty back from the unwound integrator value.

// File: rtl/pi_reg_pkg.sv
package pi_reg_pkg;
  typedef struct packed {
    logic loadErr;
    logic commit;
  } pi_strobe_t;
endpackage

// File: rtl/pi_reg_ctrl.sv
module pi_reg_ctrl
  import pi_reg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       updateStrobe,
  output pi_strobe_t ctrl,
  output logic       dutyValid
);
  logic pendingQ;
  logic validQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      pendingQ <= 1'b0;
      validQ   <= 1'b0;
    end else begin
      pendingQ <= updateStrobe;
      validQ   <= pendingQ;
    end
  end

  always_comb begin
    ctrl.loadErr = updateStrobe;
    ctrl.commit  = pendingQ;
  end

  assign dutyValid = validQ;
endmodule

// File: rtl/pi_reg_datapath.sv
module pi_reg_datapath
  import pi_reg_pkg::*;
#(
  parameter int SPEED_W = 16,
  parameter int GAIN_W  = 16,
  parameter int FRAC_W  = 8,
  parameter int DUTY_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  pi_strobe_t                ctrl,
  input  logic signed [SPEED_W-1:0] refSpeed,
  input  logic signed [SPEED_W-1:0] actSpeed,
  input  logic        [GAIN_W-1:0]  gainP,
  input  logic        [GAIN_W-1:0]  gainI,
  output logic        [DUTY_W-1:0]  duty
);
  localparam int ERR_W  = SPEED_W + 1;
  localparam int PROD_W = ERR_W + GAIN_W + 1;
  localparam int ACC_W  = PROD_W + 2;
  localparam logic signed [ACC_W-1:0] DUTY_MAX = ACC_W'((1 << DUTY_W) - 1);

  logic signed [ERR_W-1:0]  errQ;
  logic signed [ERR_W-1:0]  errNext;
  logic signed [PROD_W-1:0] errX, kpX, kiX, pProd, iProd;
  logic signed [ACC_W-1:0]  pTerm, iTerm, integQ, integNext, sum;
  logic                     satHi, satLo, errPos, errNeg, holdInteg;
  logic        [DUTY_W-1:0] dutyNext, dutyQ;

  always_comb begin
    errNext = ERR_W'(refSpeed) - ERR_W'(actSpeed);
  end

  always_ff @(posedge clk) begin
    if (rst) errQ <= '0;
    else if (ctrl.loadErr) errQ <= errNext;
  end

  always_comb begin
    errX      = PROD_W'(errQ);
    kpX       = $signed(PROD_W'(gainP));
    kiX       = $signed(PROD_W'(gainI));
    pProd     = errX * kpX;
    iProd     = errX * kiX;
    pTerm     = ACC_W'(pProd >>> FRAC_W);
    iTerm     = ACC_W'(iProd >>> FRAC_W);
    integNext = integQ + iTerm;
    sum       = pTerm + integNext;
    satHi     = sum > DUTY_MAX;
    satLo     = sum[ACC_W-1];
    errNeg    = errQ[ERR_W-1];
    errPos    = !errQ[ERR_W-1] && (errQ != '0);
    holdInteg = (satHi && errPos) || (satLo && errNeg);
    if (satHi)      dutyNext = '1;
    else if (satLo) dutyNext = '0;
    else            dutyNext = sum[DUTY_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      integQ <= '0;
      dutyQ  <= '0;
    end else if (ctrl.commit) begin
      dutyQ <= dutyNext;
      if (!holdInteg) integQ <= integNext;
    end
  end

  assign duty = dutyQ;
endmodule

// File: rtl/speed_pi_regulator.sv
module speed_pi_regulator
  import pi_reg_pkg::*;
#(
  parameter int SPEED_W = 16,
  parameter int GAIN_W  = 16,
  parameter int FRAC_W  = 8,
  parameter int DUTY_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      updateStrobe,
  input  logic signed [SPEED_W-1:0] refSpeed,
  input  logic signed [SPEED_W-1:0] actSpeed,
  input  logic        [GAIN_W-1:0]  gainP,
  input  logic        [GAIN_W-1:0]  gainI,
  output logic        [DUTY_W-1:0]  duty,
  output logic                      dutyValid
);
  pi_strobe_t ctrl;

  pi_reg_ctrl u_ctrl (
    .clk(clk), .rst(rst), .updateStrobe(updateStrobe),
    .ctrl(ctrl), .dutyValid(dutyValid)
  );

  pi_reg_datapath #(
    .SPEED_W(SPEED_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W), .DUTY_W(DUTY_W)
  ) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl),
    .refSpeed(refSpeed), .actSpeed(actSpeed),
    .gainP(gainP), .gainI(gainI), .duty(duty)
  );
endmodule

// File: rtl/pi_reg_checker.sv
module pi_reg_checker #(
  parameter int DUTY_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              updateStrobe,
  input logic [DUTY_W-1:0] duty,
  input logic              dutyValid
);
  // R1: reset leaves a zero duty and no valid pulse
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (duty == '0 && !dutyValid));

  // R3: a strobe is answered two edges later
  a_r3_valid_after_two: assert property (@(posedge clk) disable iff (rst)
    updateStrobe |-> ##2 dutyValid);

  // R3: no valid pulse without a strobe two cycles earlier
  a_r3_valid_has_cause: assert property (@(posedge clk) disable iff (rst)
    dutyValid |-> $past(updateStrobe, 2));

  // R9: duty only moves together with a valid pulse
  a_r9_duty_holds: assert property (@(posedge clk) disable iff (rst)
    !dutyValid |-> $stable(duty));
endmodule

bind speed_pi_regulator pi_reg_checker #(.DUTY_W(DUTY_W)) chk (
  .clk(clk), .rst(rst), .updateStrobe(updateStrobe),
  .duty(duty), .dutyValid(dutyValid)
);

// File: tb/tb_speed_pi_regulator.sv
module tb_speed_pi_regulator;
  localparam int CLK_PERIOD = 10;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               updateStrobe = 1'b0;
  logic signed [15:0] refSpeed = '0;
  logic signed [15:0] actSpeed = '0;
  logic        [15:0] gainP = '0;
  logic        [15:0] gainI = '0;
  logic        [7:0]  duty;
  logic               dutyValid;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  longint integM = 0;

  speed_pi_regulator dut (
    .clk(clk), .rst(rst), .updateStrobe(updateStrobe),
    .refSpeed(refSpeed), .actSpeed(actSpeed),
    .gainP(gainP), .gainI(gainI), .duty(duty), .dutyValid(dutyValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Model of one update from the requirements (R4 R5 R6 R7)
  function automatic int modelStep(input int r, input int a, input int kp, input int ki);
    longint e, p, iNew, s;
    int d;
    e    = longint'(r) - longint'(a);
    p    = (longint'(kp) * e) >>> 8;
    iNew = integM + ((longint'(ki) * e) >>> 8);
    s    = p + iNew;
    d    = (s > 255) ? 255 : (s < 0) ? 0 : int'(s);
    if (!((s > 255 && e > 0) || (s < 0 && e < 0))) integM = iNew;
    return d;
  endfunction

  task automatic applyReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    integM = 0;
  endtask

  task automatic doUpdate(input string req, input int r, input int a, input int kp, input int ki);
    int exp;
    refSpeed = 16'(r); actSpeed = 16'(a); gainP = 16'(kp); gainI = 16'(ki);
    exp = modelStep(r, a, kp, ki);
    updateStrobe = 1'b1;
    @(negedge clk);
    updateStrobe = 1'b0;
    @(negedge clk);
    check({req, " valid"}, dutyValid, 1);
    check({req, " duty"}, duty, exp);
    @(negedge clk);
    check({req, " pulse width"}, dutyValid, 0);
  endtask

  task automatic testReset();
    applyReset();
    check("R1 duty after reset", duty, 0);
    check("R1 valid after reset", dutyValid, 0);
  endtask

  task automatic testProportional();
    doUpdate("R4 unity gain", 300, 200, 16'h0100, 0);
    doUpdate("R4 half gain floor", 10, 3, 16'h0080, 0);
    doUpdate("R4 negative err floors low", -3, 0, 16'h0180, 0);
    doUpdate("R2 signed error", -100, -250, 16'h0100, 0);
  endtask

  task automatic testIntegral();
    applyReset();
    for (int k = 0; k < 3; k++) doUpdate("R5 ramp up", 140, 100, 0, 16'h0040);
    for (int k = 0; k < 4; k++) doUpdate("R6 ramp below zero", 0, 40, 0, 16'h0040);
  endtask

  task automatic testAntiWindup();
    applyReset();
    doUpdate("R6 below limit", 200, 0, 0, 16'h0100);
    doUpdate("R7 clamp high", 200, 0, 0, 16'h0100);
    doUpdate("R7 clamp high again", 200, 0, 0, 16'h0100);
    doUpdate("R7 recovers on reversal", 0, 50, 0, 16'h0100);
    doUpdate("R7 low side", 0, 500, 0, 16'h0100);
    doUpdate("R7 low side recovers", 100, 0, 0, 16'h0100);
  endtask

  task automatic testBackToBack();
    int e1, e2;
    applyReset();
    gainP = 16'h0100; gainI = 16'h0080;
    e1 = modelStep(60, 0, 16'h0100, 16'h0080);
    e2 = modelStep(20, 0, 16'h0100, 16'h0080);
    refSpeed = 16'sd60; actSpeed = 0; updateStrobe = 1'b1;
    @(negedge clk);
    refSpeed = 16'sd20;
    @(negedge clk);
    updateStrobe = 1'b0;
    check("R8 first valid", dutyValid, 1);
    check("R8 first duty", duty, e1);
    @(negedge clk);
    check("R8 second valid", dutyValid, 1);
    check("R8 second duty", duty, e2);
    @(negedge clk);
    check("R8 valid ends", dutyValid, 0);
  endtask

  task automatic testHold();
    logic [7:0] held;
    doUpdate("R9 setup", 30, 0, 16'h0100, 0);
    held = duty;
    for (int k = 0; k < 5; k++) begin
      refSpeed = 16'(1000 * k); actSpeed = 16'(-7 * k); gainP = 16'(k * 99); gainI = 16'h0200;
      @(negedge clk);
      check("R9 duty held", duty, held);
      check("R9 no valid", dutyValid, 0);
    end
  endtask

  task automatic testResetClearsIntegrator();
    doUpdate("R1 build integral", 100, 0, 0, 16'h0100);
    applyReset();
    doUpdate("R1 integrator cleared", 0, 0, 0, 0);
  endtask

  initial begin
    testReset();
    testProportional();
    testIntegral();
    testAntiWindup();
    testBackToBack();
    testHold();
    testResetClearsIntegrator();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule